// File: doc/BRIEF.md
# Video Dot Serializer with Load Pulse Shaper

This block sits between a slow pixel-producing controller and a video output stage. It divides a free-running oscillator by two to form the dot clock. It shifts each byte placed on a parallel bus out as eight serial pixels, one per dot.

The controller cannot make short pulses. It marks each byte with a high-going request strobe that is at least two dot clocks wide. The block retimes the strobe into the dot domain and cuts it down to a single active-low load pulse exactly one dot wide. The pulse changes only on falling dot edges, so it is steady at every rising dot edge, where the shift register acts.

A text line is a run of byte loads spaced eight dots apart. The stream is gapless. After the last byte the controller loads a zero byte, and the output stays black until the next line.

Top module: `dot_serializer`

## Requirements
- R1: `dot_clk_o` toggles on every rising `clk_i` edge. Its first rising edge falls on the first `clk_i` edge after reset release.
- R2: While `rst_ni` is low, and immediately when it falls, `dot_clk_o` is 0, `load_n_o` is 1 and `pixel_o` is 0.
- R3: `load_n_o` changes only at falling dot-clock edges. It therefore holds the same value on both sides of every rising dot edge.
- R4: Each request produces exactly one load pulse, and each pulse is low for exactly one dot, however long the request is held. A request is high for one or more dots and has at least two low dots before the next request. No load occurs without a request.
- R5: With the default two synchronizer stages, consider a request first driven shortly after rising dot edge k. The load then happens at rising dot edge k+3.
- R6: At the loading rising dot edge `pixel_o` takes bit 7 of `data_i`. The next seven rising dot edges then present bits 6 down to 0, so the most significant bit comes first.
- R7: Once eight pixels of a byte have been sent with no new load, `pixel_o` stays 0.
- R8: Loads spaced exactly eight dots apart give a continuous pixel stream with no gap or repeated pixel. A trailing zero byte blanks the rest of the line.
- R9: `data_i` is sampled only at the loading rising dot edge. Its value at any other time does not affect the pixel stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock (twice the dot rate) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_req_i | input | 1 | High-going byte load request from the controller |
| data_i | input | PIX_W | Pixel byte to load |
| dot_clk_o | output | 1 | Dot clock, oscillator divided by two |
| load_n_o | output | 1 | Active-low one-dot parallel load pulse |
| pixel_o | output | 1 | Serial pixel, most significant bit first |

## Verification
The bench goes after held requests up to six dots long. A shaper that only delays the strobe would emit a pulse as wide as the request, and this would show up as a duplicated load and repeated first pixels. It checks the exact load dot: a shaper missing a synchronizer stage or a delay register would load one dot early or late against the scrambled data bus, and would capture a wrong byte. Back-to-back lines of 45 bytes expose dropped or duplicated shifts at the eight-dot seam. Idle gaps and a mid-byte asynchronous reset show whether ones leak back into the stream or survive reset.

// File: rtl/dot_ser_pkg.sv
package dot_ser_pkg;
  localparam int unsigned DEF_PIX_W  = 8;
  localparam int unsigned DEF_SYNC_N = 2;

  // strobes valid for the coming clk_i edge
  typedef struct packed {
    logic rise;
    logic fall;
  } dot_evt_t;
endpackage

// File: rtl/dot_clk_div.sv
module dot_clk_div
  import dot_ser_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  output logic     dot_clk_o,
  output dot_evt_t evt_o
);
  logic dot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dot_q <= 1'b0;
    else         dot_q <= ~dot_q;
  end

  assign dot_clk_o  = dot_q;
  assign evt_o.rise = ~dot_q;
  assign evt_o.fall = dot_q;
endmodule

// File: rtl/load_shaper.sv
module load_shaper #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_en_i,
  input  logic req_i,
  output logic load_n_o
);
  localparam int unsigned TOP = SYNC_N - 1;

  logic [SYNC_N-1:0] sync_q;
  logic              dly_q;
  logic              load_n_q;

  // synchronizer, advanced on falling dot edges only
  for (genvar i = 0; i < SYNC_N; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        sync_q[i] <= 1'b0;
        else if (fall_en_i) sync_q[i] <= req_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        sync_q[i] <= 1'b0;
        else if (fall_en_i) sync_q[i] <= sync_q[i-1];
      end
    end
  end

  // one-dot delayed copy, cut against the live strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q    <= 1'b0;
      load_n_q <= 1'b1;
    end else if (fall_en_i) begin
      dly_q    <= sync_q[TOP];
      load_n_q <= ~(sync_q[TOP] & ~dly_q);
    end
  end

  assign load_n_o = load_n_q;
endmodule

// File: rtl/pixel_shifter.sv
module pixel_shifter #(
  parameter int unsigned PIX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_en_i,
  input  logic             load_n_i,
  input  logic [PIX_W-1:0] data_i,
  output logic             pixel_o
);
  logic [PIX_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             sh_q <= '0;
    else if (rise_en_i) begin
      if (!load_n_i)         sh_q <= data_i;
      else                   sh_q <= {sh_q[PIX_W-2:0], 1'b0};
    end
  end

  assign pixel_o = sh_q[PIX_W-1];
endmodule

// File: rtl/dot_serializer.sv
module dot_serializer
  import dot_ser_pkg::*;
#(
  parameter int unsigned PIX_W  = DEF_PIX_W,
  parameter int unsigned SYNC_N = DEF_SYNC_N
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_req_i,
  input  logic [PIX_W-1:0] data_i,
  output logic             dot_clk_o,
  output logic             load_n_o,
  output logic             pixel_o
);
  dot_evt_t evt;
  logic     load_n;

  dot_clk_div u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dot_clk_o(dot_clk_o),
    .evt_o    (evt)
  );

  load_shaper #(.SYNC_N(SYNC_N)) u_shape (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fall_en_i(evt.fall),
    .req_i    (load_req_i),
    .load_n_o (load_n)
  );

  pixel_shifter #(.PIX_W(PIX_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_en_i(evt.rise),
    .load_n_i (load_n),
    .data_i   (data_i),
    .pixel_o  (pixel_o)
  );

  assign load_n_o = load_n;
endmodule

// File: rtl/dot_serializer_chk.sv
module dot_serializer_chk #(
  parameter int unsigned PIX_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [PIX_W-1:0] data_i,
  input logic             dot_clk_o,
  input logic             load_n_o,
  input logic             pixel_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r2_reset_vals: assert (!dot_clk_o && load_n_o && !pixel_o)
        else $error("R2 outputs not at reset values");
    end
  end

  a_r1_dot_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (dot_clk_o != $past(dot_clk_o)));

  a_r3_load_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(load_n_o) |-> $fell(dot_clk_o));

  a_r4_pulse_two_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(load_n_o) |=> !load_n_o);

  a_r4_pulse_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_n_o && $past(!load_n_o)) |=> load_n_o);

  a_r6_msb_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dot_clk_o) && !load_n_o) |-> (pixel_o == $past(data_i[PIX_W-1])));

  a_r7_pixel_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pixel_o) |-> $rose(dot_clk_o));
endmodule

bind dot_serializer dot_serializer_chk #(.PIX_W(PIX_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .data_i   (data_i),
  .dot_clk_o(dot_clk_o),
  .load_n_o (load_n_o),
  .pixel_o  (pixel_o)
);

// File: tb/dot_serializer_test.sv
`timescale 1ns/1ps
module dot_serializer_test;
  localparam int LOAD_LAT = 3;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       load_req_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic       dot_clk_o, load_n_o, pixel_o;

  int checks = 0;
  int errors = 0;

  dot_serializer uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_req_i(load_req_i), .data_i(data_i),
    .dot_clk_o(dot_clk_o), .load_n_o(load_n_o), .pixel_o(pixel_o)
  );

  always #5 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // monitor state
  bit         mon_en = 1'b0;
  bit         line_mode = 1'b0;
  logic       prev_dot = 1'b0;
  logic       prev_load = 1'b1;
  bit         prev_was_load = 1'b0;
  int         dot_idx = 0;
  logic [7:0] exp_sh = 8'h00;
  logic [7:0] cur_byte = 8'h00;
  logic [7:0] got_byte = 8'h00;
  int         bits_left = 0;
  logic [7:0] byte_q[$];
  int         due_q[$];

  task automatic mon_clear();
    byte_q.delete();
    due_q.delete();
    prev_dot = 1'b0;
    prev_load = 1'b1;
    prev_was_load = 1'b0;
    exp_sh = 8'h00;
    bits_left = 0;
  endtask

  always @(negedge clk_i) begin
    if (mon_en) begin
      chk(dot_clk_o != prev_dot, "R1", int'(dot_clk_o), int'(!prev_dot));
      if (dot_clk_o && !prev_dot) begin
        dot_idx++;
        chk(load_n_o == prev_load, "R3", int'(load_n_o), int'(prev_load));
        if (!load_n_o) begin
          chk(!prev_was_load, "R4", 1, 0);
          chk(byte_q.size() > 0, "R4", 1, 0);
          if (byte_q.size() > 0) begin
            chk(dot_idx == due_q[0], "R5", dot_idx, due_q[0]);
            cur_byte = byte_q.pop_front();
            void'(due_q.pop_front());
            exp_sh = cur_byte;
            bits_left = 8;
            got_byte = 8'h00;
          end
        end
        prev_was_load = !load_n_o;
        if (bits_left > 0) begin
          chk(pixel_o == exp_sh[7], line_mode ? "R8" : "R6", int'(pixel_o), int'(exp_sh[7]));
          got_byte = {got_byte[6:0], pixel_o};
          bits_left--;
          // R9: byte reassembled despite the scrambled bus
          if (bits_left == 0) chk(got_byte == cur_byte, "R9", got_byte, cur_byte);
        end else begin
          chk(pixel_o == 1'b0, line_mode ? "R8" : "R7", int'(pixel_o), 0);
        end
        exp_sh = {exp_sh[6:0], 1'b0};
        if (due_q.size() > 0 && due_q[0] < dot_idx) begin
          chk(1'b0, "R4", 0, 1);
          void'(byte_q.pop_front());
          void'(due_q.pop_front());
        end
      end
      prev_dot = dot_clk_o;
      prev_load = load_n_o;
    end
  end

  // one request of given width, period dots long; data valid only at load
  task automatic send(input logic [7:0] b, input int width, input int period);
    for (int j = 0; j < period; j++) begin
      @(posedge dot_clk_o);
      #1;
      if (j == 0) begin
        byte_q.push_back(b);
        due_q.push_back(dot_idx + 1 + LOAD_LAT);
      end
      load_req_i = (j < width);
      data_i = (j == LOAD_LAT - 1) ? b : 8'($urandom());
    end
  endtask

  task automatic idle(input int n);
    for (int j = 0; j < n; j++) begin
      @(posedge dot_clk_o);
      #1;
      load_req_i = 1'b0;
      data_i = 8'($urandom());
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    mon_en = 1'b0;
    mon_clear();
    repeat (4) @(posedge clk_i);
    #1;
    chk(dot_clk_o == 1'b0, "R2", int'(dot_clk_o), 0);
    chk(load_n_o == 1'b1, "R2", int'(load_n_o), 1);
    chk(pixel_o == 1'b0, "R2", int'(pixel_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1 mon_en = 1'b1;
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin
      @(posedge clk_i);
      wd++;
    end
    errors++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_ni = 1'b1;
    #2;
    do_reset();

    // directed single bytes, minimum strobe
    send(8'hA5, 2, 10);
    send(8'h81, 2, 12);
    send(8'hFF, 2, 12);
    idle(6);

    // R4: held requests still give one pulse each
    send(8'h3C, 6, 12);
    send(8'hC3, 4, 10);
    idle(4);

    // R8: two full lines, 45 bytes each, then a zero byte
    line_mode = 1'b1;
    for (int ln = 0; ln < 2; ln++) begin
      for (int k = 0; k < 45; k++) send(8'($urandom()), 2, 8);
      send(8'h00, 2, 8);
      idle(12);
    end
    line_mode = 1'b0;

    // random widths, spacings and bytes
    for (int k = 0; k < 150; k++) begin
      int w;
      int p;
      w = 2 + int'($urandom_range(4));
      p = w + 2 + int'($urandom_range(6));
      if (p < 8) p = 8;
      send(8'($urandom()), w, p);
    end
    idle(12);
    chk(byte_q.size() == 0, "R4", byte_q.size(), 0);

    // R2: asynchronous reset in the middle of a byte
    send(8'hFF, 2, 5);
    #3;
    rst_ni = 1'b0;
    mon_en = 1'b0;
    #1;
    chk(dot_clk_o == 1'b0, "R2", int'(dot_clk_o), 0);
    chk(load_n_o == 1'b1, "R2", int'(load_n_o), 1);
    chk(pixel_o == 1'b0, "R2", int'(pixel_o), 0);
    do_reset();
    idle(10);
    send(8'h6B, 3, 12);
    idle(4);
    chk(byte_q.size() == 0, "R4", byte_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule